// File: doc/BRIEF.md
# DMA Channel Bus Cycle Sequencer

This block sequences the bus cycles of one DMA channel while a block of items moves between memory and an I/O device. A single-clock `start` pulse loads the block setup: cycle mode, direction, item size, start address and item count. For the whole block the sequencer holds the channel acknowledge low. It pulses the I/O read strobe or the I/O write strobe once per item, keeps a memory address counter, and counts down the items still to move. The I/O device is selected only by the acknowledge together with a strobe. No I/O address is driven.

In fixed mode every item takes a compressed cycle of four bus clocks. In burst mode the sequencer samples the active-low slave burst input during the first clock of the block. If that input is low, the first item completes in that clock. The sequencer then drives its own active-low burst output for the remainder of the block and moves one item on every clock. If the input is high, the block falls back to fixed timing until it ends. After the last item, every bus line is released and the terminal count output pulses for one clock.

Top module: `dma_burst_seq`

## Requirements
- R1: During and after a synchronous reset, `dack_n`, `ior_n`, `iow_n` and `mst_burst_n` are high and `tc` is low.
- R2: A `start` pulse is acted on only when the block is idle and `cfg_count` is nonzero. When it is acted on, `dack_n` goes low in the next clock. A `start` with a zero count, or a `start` during a block, changes no output.
- R3: Direction code 1 (memory to I/O) uses `iow_n`, and direction code 0 (I/O to memory) uses `ior_n`. The strobe that is not selected stays high for the whole block.
- R4: In fixed mode (`cfg_burst`=0) each item takes exactly 4 clocks. The strobe is low for the first 3 of them and high for the 4th, and `slv_burst_n` has no effect.
- R5: In burst mode (`cfg_burst`=1), `slv_burst_n` is sampled only in the first clock of a block. If it is low, an N-item block holds the strobe low for N consecutive clocks and lasts N clocks.
- R6: In a burst-granted block, `mst_burst_n` is low from the second clock through the last item, which is N-1 clocks. It is never low in a block that uses fixed timing.
- R7: In burst mode, if `slv_burst_n` is high in the first clock, the whole block uses fixed 4-clock timing, even if `slv_burst_n` goes low later.
- R8: `dack_n` stays low without a break from the first clock of a block through the clock of its last item.
- R9: `tc` is high for exactly one clock, the clock right after the last item. In that clock, `dack_n`, both strobes and `mst_burst_n` are already high.
- R10: `mem_addr` equals `cfg_addr` in the first clock of a block and advances once per item. The step is 1, 2 or 4 for size codes 0, 1 and 2, and code 3 is treated as 4. After an N-item block, `mem_addr` equals `cfg_addr` + N×step.
- R11: `ior_n` and `iow_n` are never low together. A strobe or `mst_burst_n` is low only while `dack_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-clock request to begin a block |
| cfg_burst | input | 1 | 1 = burst mode, 0 = fixed 4-clock mode |
| cfg_dir | input | 1 | 1 = memory to I/O, 0 = I/O to memory |
| cfg_size | input | 2 | Item size code: 0 = 8-bit, 1 = 16-bit, 2 and 3 = 32-bit |
| cfg_addr | input | ADDR_W | Start memory address |
| cfg_count | input | CNT_W | Number of items in the block |
| slv_burst_n | input | 1 | Memory reports it can burst, active low |
| dack_n | output | 1 | Channel acknowledge to the I/O device, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| mst_burst_n | output | 1 | Sequencer is bursting, active low |
| tc | output | 1 | Terminal count pulse |
| mem_addr | output | ADDR_W | Address of the current item |

## Verification
The bench sweeps both modes, grant and no grant, both directions, all four size codes and several block lengths. For each block it counts the clocks of acknowledge, strobe and burst output, locates the terminal count pulse, and checks the start and end addresses against arithmetic. A slave burst signal that arrives one clock late has to leave the block at fixed timing. A sequencer that sampled the input on every clock would switch to bursting part way through, which shortens the block and gives a nonzero burst output count. Single-item bursts check that the burst output never goes low. Zero-count starts and starts issued mid-block have to leave the block length and addresses unchanged. An off-by-one phase counter, a misplaced strobe gap or a wrong size step would show up as a wrong clock count or a wrong final address.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } item_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } seq_state_e;

  // Address step in bytes for one item; the reserved code moves 32 bits.
  function automatic logic [2:0] size_step(input logic [1:0] code);
    case (item_size_e'(code))
      SZ_BYTE: size_step = 3'd1;
      SZ_WORD: size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_phase.sv
module dma_seq_phase #(
  parameter int FIXED_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic ph_last,
  output logic ph_gap
);
  localparam int PH_W = (FIXED_CLKS > 2) ? $clog2(FIXED_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FIXED_CLKS - 1);
  localparam logic [PH_W-1:0] PH_PRE  = PH_W'(FIXED_CLKS - 2);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ph_q <= '0;
    end else if (run) begin
      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
    end
  end

  assign ph_last = (ph_q == PH_LAST);
  // The next phase is the recovery clock with the strobe off.
  assign ph_gap  = (ph_q == PH_PRE);

endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [1:0]        load_size,
  output logic [ADDR_W-1:0] addr,
  output logic              cnt_last
);
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      addr   <= '0;
      step_q <= 3'd1;
    end else if (load) begin
      cnt_q  <= load_cnt;
      addr   <= load_addr;
      step_q <= size_step(load_size);
    end else if (adv) begin
      cnt_q  <= cnt_q - CNT_W'(1);
      addr   <= addr + ADDR_W'(step_q);
    end
  end

  assign cnt_last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cnt_zero,
  input  logic cfg_burst,
  input  logic cfg_dir,
  input  logic slv_burst_n,
  input  logic ph_last,
  input  logic ph_gap,
  input  logic cnt_last,
  output logic launch,
  output logic item_done,
  output logic ph_run,
  output logic dack_n,
  output logic ior_n,
  output logic iow_n,
  output logic mst_burst_n,
  output logic tc
);
  seq_state_e state_q;
  logic first_q, burst_q, mode_q, dir_q;
  logic in_xfer, grant_now, fast, finish, strobe_n_nxt;

  assign in_xfer   = (state_q == ST_XFER);
  assign launch    = (state_q == ST_IDLE) && start && !cnt_zero;
  assign grant_now = first_q && mode_q && !slv_burst_n;
  assign fast      = burst_q || grant_now;
  assign item_done = in_xfer && (fast || ph_last);
  assign finish    = item_done && cnt_last;
  assign ph_run    = in_xfer && !fast;

  always_comb begin
    if (fast) strobe_n_nxt = 1'b0;
    else      strobe_n_nxt = ph_gap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      first_q     <= 1'b0;
      burst_q     <= 1'b0;
      mode_q      <= 1'b0;
      dir_q       <= 1'b0;
      dack_n      <= 1'b1;
      ior_n       <= 1'b1;
      iow_n       <= 1'b1;
      mst_burst_n <= 1'b1;
      tc          <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (launch) begin
        state_q     <= ST_XFER;
        first_q     <= 1'b1;
        burst_q     <= 1'b0;
        mode_q      <= cfg_burst;
        dir_q       <= cfg_dir;
        dack_n      <= 1'b0;
        ior_n       <= cfg_dir;
        iow_n       <= !cfg_dir;
        mst_burst_n <= 1'b1;
      end else if (in_xfer) begin
        first_q <= 1'b0;
        if (finish) begin
          state_q     <= ST_IDLE;
          burst_q     <= 1'b0;
          dack_n      <= 1'b1;
          ior_n       <= 1'b1;
          iow_n       <= 1'b1;
          mst_burst_n <= 1'b1;
          tc          <= 1'b1;
        end else begin
          if (fast) begin
            burst_q     <= 1'b1;
            mst_burst_n <= 1'b0;
          end
          ior_n <= dir_q  ? 1'b1 : strobe_n_nxt;
          iow_n <= !dir_q ? 1'b1 : strobe_n_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  parameter int FIXED_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_burst,
  input  logic              cfg_dir,
  input  logic [1:0]        cfg_size,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              slv_burst_n,
  output logic              dack_n,
  output logic              ior_n,
  output logic              iow_n,
  output logic              mst_burst_n,
  output logic              tc,
  output logic [ADDR_W-1:0] mem_addr
);
  logic launch, item_done, ph_run, ph_last, ph_gap, cnt_last;

  dma_seq_phase #(.FIXED_CLKS(FIXED_CLKS)) i_phase (
    .clk(clk), .rst(rst), .clear(launch), .run(ph_run),
    .ph_last(ph_last), .ph_gap(ph_gap)
  );

  dma_seq_count #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_count (
    .clk(clk), .rst(rst), .load(launch), .adv(item_done),
    .load_addr(cfg_addr), .load_cnt(cfg_count), .load_size(cfg_size),
    .addr(mem_addr), .cnt_last(cnt_last)
  );

  dma_seq_ctrl i_ctrl (
    .clk(clk), .rst(rst), .start(start), .cnt_zero(cfg_count == '0),
    .cfg_burst(cfg_burst), .cfg_dir(cfg_dir), .slv_burst_n(slv_burst_n),
    .ph_last(ph_last), .ph_gap(ph_gap), .cnt_last(cnt_last),
    .launch(launch), .item_done(item_done), .ph_run(ph_run),
    .dack_n(dack_n), .ior_n(ior_n), .iow_n(iow_n),
    .mst_burst_n(mst_burst_n), .tc(tc)
  );

endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk (
  input logic clk,
  input logic rst,
  input logic dack_n,
  input logic ior_n,
  input logic iow_n,
  input logic mst_burst_n,
  input logic tc
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!ior_n && !iow_n));

  // R11
  strobe_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!ior_n || !iow_n) |-> !dack_n);

  // R6
  burst_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !mst_burst_n |-> (!dack_n && (!ior_n || !iow_n)));

  // R9
  tc_single_chk: assert property (@(posedge clk) disable iff (rst)
    tc |=> !tc);

  // R9
  tc_release_chk: assert property (@(posedge clk) disable iff (rst)
    tc |-> (dack_n && ior_n && iow_n && mst_burst_n && $past(!dack_n)));

  // R8
  ack_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dack_n) |-> tc);
endmodule

bind dma_burst_seq dma_burst_seq_chk i_chk (
  .clk(clk), .rst(rst), .dack_n(dack_n), .ior_n(ior_n), .iow_n(iow_n),
  .mst_burst_n(mst_burst_n), .tc(tc)
);

// File: tb/test_dma_burst_seq.sv
module test_dma_burst_seq;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cfg_burst = 1'b0, cfg_dir = 1'b0, slv_burst_n = 1'b1;
  logic [1:0] cfg_size = 2'd0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic dack_n, ior_n, iow_n, mst_burst_n, tc;
  logic [ADDR_W-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_burst_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_dma_burst_seq (
    .clk(clk), .rst(rst), .start(start), .cfg_burst(cfg_burst),
    .cfg_dir(cfg_dir), .cfg_size(cfg_size), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .slv_burst_n(slv_burst_n), .dack_n(dack_n),
    .ior_n(ior_n), .iow_n(iow_n), .mst_burst_n(mst_burst_n), .tc(tc),
    .mem_addr(mem_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_block(input bit mode, input bit grant, input bit late,
                           input bit dir, input logic [1:0] size, input int n,
                           input bit restart);
    int dlow = 0, rlow = 0, wlow = 0, mlow = 0, tcs = 0, tc_at = -1;
    int first_addr = -1, step, base, len, fast;
    step = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    base = 'h100 + n * 16 + int'(size);
    fast = (mode && grant && !late) ? 1 : 0;
    len  = fast ? n : 4 * n;
    @(negedge clk);
    cfg_burst = mode; cfg_dir = dir; cfg_size = size;
    cfg_addr = ADDR_W'(base); cfg_count = CNT_W'(n);
    slv_burst_n = !(grant && !late);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4 * n + 3; i++) begin
      if (!dack_n) dlow++;
      if (!ior_n) rlow++;
      if (!iow_n) wlow++;
      if (!mst_burst_n) mlow++;
      if (tc) begin tcs++; tc_at = i; end
      if (i == 0) first_addr = int'(mem_addr);
      if (late && i == 1) slv_burst_n = 1'b0;
      if (restart && i == 1) begin start = 1'b1; cfg_count = 8'd7; end
      if (restart && i == 2) start = 1'b0;
      @(negedge clk);
    end
    slv_burst_n = 1'b1;
    // R8 acknowledge held for the whole block
    check(dlow == len, "R8 dack length", dlow, len);
    // R9 single terminal count just after last item
    check(tcs == 1 && tc_at == len, "R9 tc position", tc_at, len);
    // R3 selected strobe, R4/R5 strobe clocks
    if (dir) begin
      check(wlow == (fast ? n : 3 * n), "R3/R4/R5 iow low clocks", wlow, fast ? n : 3 * n);
      check(rlow == 0, "R3 ior unused", rlow, 0);
    end else begin
      check(rlow == (fast ? n : 3 * n), "R3/R4/R5 ior low clocks", rlow, fast ? n : 3 * n);
      check(wlow == 0, "R3 iow unused", wlow, 0);
    end
    // R6 and R7 burst output
    check(mlow == (fast ? n - 1 : 0), "R6/R7 mst_burst clocks", mlow, fast ? n - 1 : 0);
    // R10 addresses
    check(first_addr == base, "R10 first address", first_addr, base);
    check(int'(mem_addr) == base + n * step, "R10 final address",
          int'(mem_addr), base + n * step);
    if (restart) check(dlow == len, "R2 start during block ignored", dlow, len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dack_n && ior_n && iow_n && mst_burst_n && !tc, "R1 reset outputs",
          {dack_n, ior_n, iow_n, mst_burst_n, tc}, 5'b11110);
    rst = 1'b0;
    @(negedge clk);
    check(dack_n && ior_n && iow_n && mst_burst_n && !tc, "R1 after reset",
          {dack_n, ior_n, iow_n, mst_burst_n, tc}, 5'b11110);

    // R2 zero count start is ignored
    cfg_count = '0; cfg_addr = 16'h0040; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check(dack_n && ior_n && iow_n && !tc, "R2 zero count ignored", dack_n, 1);
      @(negedge clk);
    end

    // Sweep of mode, grant, direction, size and length (R3..R10)
    for (int m = 0; m < 2; m++)
      for (int g = 0; g < 2; g++)
        for (int d = 0; d < 2; d++)
          for (int s = 0; s < 4; s++)
            foreach (lens[k])
              run_block(m[0], g[0], 1'b0, d[0], s[1:0], lens[k], 1'b0);

    // R7 grant arriving after the first clock leaves fixed timing
    run_block(1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 3, 1'b0);
    run_block(1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 5, 1'b0);
    // R4 slave burst ignored in fixed mode
    run_block(1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 4, 1'b0);
    // R2 start during an active block is ignored
    run_block(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2, 1'b1);
    run_block(1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 4, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int lens[4] = '{1, 2, 3, 5};

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule